// File: doc/BRIEF.md
# Lookup-Based Attention Score Engine

This block scores one query against a run of stored keys. The keys are kept only as their norm and as small codebook indices per coordinate. Scoring happens entirely in the rotated domain, so no key is ever dequantized and there is no inverse rotation. The query arrives already rotated and is latched when it is accepted. The engine then fills a product table: for every coordinate it holds the query value times each entry of a fixed, design-time codebook. All coordinates are filled in parallel, one codebook entry per cycle.

Once the table is complete, the engine reads the keys from an external storage port in address order, one per cycle. For each key it picks one table entry per coordinate using that key's indices, adds the picked entries through a reduction adder, and multiplies the sum by the key's norm. That multiply is the only one made per key. Scores stream out in address order with a valid flag and a last flag. The caller supplies a key count, and a new query is taken only after the final score of the previous one has left the block.

Top module: `attn_score_engine`

## Requirements
- R1: After reset, q_ready is 1, while s_valid, s_last and kr_en are 0.
- R2: A query is accepted in a cycle where q_valid and q_ready are both 1. q_ready stays 0 from the next cycle until the cycle after the score flagged s_last. q_valid asserted while q_ready is 0 has no effect on the scores or on the number of scores produced.
- R3: The codebook entry for index j is (2j − (2^B − 1))·CSTEP, which gives −63, −45, … , 63 for the defaults B=3 and CSTEP=9. Query coordinate c is the signed two's-complement field q_data[c·QW +: QW]. The index of coordinate c is kr_idx[c·B +: B].
- R4: Each score equals kr_norm, taken as unsigned, times the sum over all coordinates c of q[c]·centroid(idx[c]). It is exact in SW signed bits.
- R5: The first key read (kr_en high) happens exactly 2^B + 2 cycles after the acceptance cycle. No key read occurs before the product table is complete.
- R6: Key reads use addresses 0, 1, …, T−1 in consecutive cycles, with kr_en high for exactly T cycles per query. Storage returns kr_idx and kr_norm one cycle after kr_en.
- R7: Each score appears with s_valid exactly 3 cycles after the kr_en cycle of its key, and scores come out in address order.
- R8: s_last is 1 only on the score of key T−1. When T=1, the single score carries s_last.
- R9: key_count T may take any value from 1 to 2^AW, including the full 2^AW.
- R10: s_valid is never 1 while q_ready is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| q_valid | input | 1 | Query offered |
| q_ready | output | 1 | Engine idle, query can be taken |
| q_data | input | D*QW | Rotated query, signed coordinates packed |
| key_count | input | AW+1 | Number of keys T to score (1..2^AW) |
| kr_en | output | 1 | Key storage read enable |
| kr_addr | output | AW | Key storage read address |
| kr_idx | input | D*B | Codebook indices of the key read last cycle |
| kr_norm | input | NW | Unsigned norm of the key read last cycle |
| s_valid | output | 1 | Score valid |
| s_last | output | 1 | Score belongs to key T−1 |
| s_score | output | SW | Signed score |

## Verification
The hardest case to reach is a query request that arrives while an earlier query is still being scored: it must neither disturb the table nor cut the current run short. The bench raises q_valid with different query data for several cycles in the middle of a read burst and drops it before the run ends. The scoreboard then requires every score, and the score count, to match the first query. Runs at the extremes of the counter range (a single key and the full 2^AW keys), together with a run where every product sits at its largest magnitude, exercise the last-flag logic, the address wrap and the result width.

// File: rtl/asc_pkg.sv
package asc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_BUILD,
        ST_READ,
        ST_DRAIN
    } ctrl_state_e;

    typedef struct packed {
        logic valid;
        logic last;
    } pipe_tag_t;

    // Symmetric uniform codebook, fixed at design time
    function automatic int centroid_value(input int idx, input int levels, input int step);
        return (2 * idx - (levels - 1)) * step;
    endfunction

endpackage

// File: rtl/asc_table.sv
module asc_table #(
    parameter int D     = 16,
    parameter int B     = 3,
    parameter int QW    = 8,
    parameter int CW    = 8,
    parameter int CSTEP = 9
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start,
    input  logic [D*QW-1:0]      q_flat,
    input  logic [D*B-1:0]       idx_flat,
    output logic                 ready,
    output logic [D*(QW+CW)-1:0] sel_flat
);
    localparam int NC = 1 << B;
    localparam int PW = QW + CW;
    localparam logic [B-1:0] LAST_COL = B'(NC - 1);

    logic                 building;
    logic [B-1:0]         col;
    logic signed [CW-1:0] cent_w;

    assign cent_w = CW'(asc_pkg::centroid_value(int'(col), NC, CSTEP));

    always_ff @(posedge clk) begin
        if (rst) begin
            building <= 1'b0;
            col      <= '0;
            ready    <= 1'b0;
        end else if (start) begin
            building <= 1'b1;
            col      <= '0;
            ready    <= 1'b0;
        end else if (building) begin
            col <= col + 1'b1;
            if (col == LAST_COL) begin
                building <= 1'b0;
                ready    <= 1'b1;
            end
        end
    end

    for (genvar c = 0; c < D; c++) begin : g_bank
        logic signed [QW-1:0] qc;
        logic signed [PW-1:0] bank [NC];
        logic signed [PW-1:0] prod;

        assign prod = PW'(qc) * PW'(cent_w);

        always_ff @(posedge clk) begin
            if (start) qc <= q_flat[c*QW +: QW];
            if (building) bank[col] <= prod;
        end

        assign sel_flat[c*PW +: PW] = bank[idx_flat[c*B +: B]];
    end

endmodule

// File: rtl/asc_gather.sv
module asc_gather #(
    parameter int D  = 16,
    parameter int PW = 16,
    parameter int NW = 8,
    localparam int SUMW = PW + $clog2(D),
    localparam int SW   = SUMW + NW
) (
    input  logic                 clk,
    input  logic                 rst,
    input  asc_pkg::pipe_tag_t   in_tag,
    input  logic [D*PW-1:0]      sel_flat,
    input  logic [NW-1:0]        norm,
    output asc_pkg::pipe_tag_t   out_tag,
    output logic signed [SW-1:0] out_score
);
    logic signed [SUMW-1:0] sum_c;
    logic signed [SUMW-1:0] s1_sum;
    logic [NW-1:0]          s1_norm;
    asc_pkg::pipe_tag_t     s1_tag;
    logic signed [SW-1:0]   prod_c;

    // Reduction of the gathered table entries
    always_comb begin
        sum_c = '0;
        for (int c = 0; c < D; c++) begin
            sum_c = sum_c + SUMW'($signed(sel_flat[c*PW +: PW]));
        end
    end

    // The single per-key multiply: sum times unsigned norm
    assign prod_c = SW'(s1_sum) * SW'($signed({1'b0, s1_norm}));

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_tag  <= '0;
            out_tag <= '0;
        end else begin
            s1_tag  <= in_tag;
            out_tag <= s1_tag;
        end
        s1_sum    <= sum_c;
        s1_norm   <= norm;
        out_score <= prod_c;
    end

    a_r8_last_needs_valid: assert property (@(posedge clk) disable iff (rst)
        out_tag.last |-> out_tag.valid);

    a_r7_stage_follows: assert property (@(posedge clk) disable iff (rst)
        out_tag.valid == $past(in_tag.valid, 2));

endmodule

// File: rtl/asc_ctrl.sv
module asc_ctrl #(
    parameter int AW = 6
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               q_valid,
    output logic               q_ready,
    input  logic [AW:0]        key_count,
    output logic               start,
    input  logic               tbl_ready,
    output logic               kr_en,
    output logic [AW-1:0]      kr_addr,
    output asc_pkg::pipe_tag_t rd_tag,
    input  asc_pkg::pipe_tag_t done_tag
);
    import asc_pkg::*;

    ctrl_state_e   state;
    logic [AW:0]   t_reg;
    logic [AW-1:0] addr;
    logic          issue_last;

    assign q_ready    = (state == ST_IDLE);
    assign start      = q_ready && q_valid;
    assign kr_en      = (state == ST_READ);
    assign kr_addr    = addr;
    assign issue_last = kr_en && ({1'b0, addr} == t_reg - 1'b1);

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            t_reg  <= '0;
            addr   <= '0;
            rd_tag <= '0;
        end else begin
            rd_tag.valid <= kr_en;
            rd_tag.last  <= issue_last;
            case (state)
                ST_IDLE: if (start) begin
                    t_reg <= key_count;
                    state <= ST_BUILD;
                end
                ST_BUILD: if (tbl_ready) begin
                    addr  <= '0;
                    state <= ST_READ;
                end
                ST_READ: begin
                    addr <= addr + 1'b1;
                    if (issue_last) state <= ST_DRAIN;
                end
                default: if (done_tag.valid && done_tag.last) state <= ST_IDLE;
            endcase
        end
    end

    a_r6_addr_step: assert property (@(posedge clk) disable iff (rst)
        kr_en && $past(kr_en) |-> kr_addr == $past(kr_addr) + 1'b1);

    a_r6_first_addr_zero: assert property (@(posedge clk) disable iff (rst)
        $rose(kr_en) |-> kr_addr == '0);

endmodule

// File: rtl/attn_score_engine.sv
module attn_score_engine #(
    parameter int D     = 16,
    parameter int B     = 3,
    parameter int QW    = 8,
    parameter int CW    = 8,
    parameter int CSTEP = 9,
    parameter int NW    = 8,
    parameter int AW    = 6,
    localparam int PW   = QW + CW,
    localparam int SW   = PW + $clog2(D) + NW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          q_valid,
    output logic          q_ready,
    input  logic [D*QW-1:0] q_data,
    input  logic [AW:0]   key_count,
    output logic          kr_en,
    output logic [AW-1:0] kr_addr,
    input  logic [D*B-1:0] kr_idx,
    input  logic [NW-1:0] kr_norm,
    output logic          s_valid,
    output logic          s_last,
    output logic [SW-1:0] s_score
);
    logic               start;
    logic               tbl_ready;
    logic [D*PW-1:0]    sel_flat;
    asc_pkg::pipe_tag_t rd_tag;
    asc_pkg::pipe_tag_t out_tag;
    logic signed [SW-1:0] score_w;

    asc_ctrl #(.AW(AW)) u_ctrl (
        .clk(clk), .rst(rst), .q_valid(q_valid), .q_ready(q_ready),
        .key_count(key_count), .start(start), .tbl_ready(tbl_ready),
        .kr_en(kr_en), .kr_addr(kr_addr), .rd_tag(rd_tag), .done_tag(out_tag)
    );

    asc_table #(.D(D), .B(B), .QW(QW), .CW(CW), .CSTEP(CSTEP)) u_table (
        .clk(clk), .rst(rst), .start(start), .q_flat(q_data),
        .idx_flat(kr_idx), .ready(tbl_ready), .sel_flat(sel_flat)
    );

    asc_gather #(.D(D), .PW(PW), .NW(NW)) u_gather (
        .clk(clk), .rst(rst), .in_tag(rd_tag), .sel_flat(sel_flat),
        .norm(kr_norm), .out_tag(out_tag), .out_score(score_w)
    );

    assign s_valid = out_tag.valid;
    assign s_last  = out_tag.last;
    assign s_score = score_w;

    a_r5_table_before_read: assert property (@(posedge clk) disable iff (rst)
        kr_en |-> tbl_ready);

    a_r7_fixed_latency: assert property (@(posedge clk) disable iff (rst)
        s_valid == $past(kr_en, 3));

    a_r10_no_score_when_idle: assert property (@(posedge clk) disable iff (rst)
        !(q_ready && s_valid));

    a_r2_busy_after_accept: assert property (@(posedge clk) disable iff (rst)
        q_valid && q_ready |=> !q_ready);

endmodule

// File: tb/tb_attn_score_engine.sv
module tb_attn_score_engine;
    localparam int D = 16, B = 3, QW = 8, CW = 8, CSTEP = 9, NW = 8, AW = 6;
    localparam int NC = 1 << B;
    localparam int SW = QW + CW + $clog2(D) + NW;
    localparam int NK = 1 << AW;

    logic clk = 1'b0, rst = 1'b1;
    logic q_valid = 1'b0;
    logic q_ready;
    logic [D*QW-1:0] q_data = '0;
    logic [AW:0] key_count = '0;
    logic kr_en;
    logic [AW-1:0] kr_addr;
    logic [D*B-1:0] kr_idx;
    logic [NW-1:0] kr_norm;
    logic s_valid, s_last;
    logic [SW-1:0] s_score;

    int n_chk = 0, n_err = 0, cyc = 0;

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    attn_score_engine #(.D(D), .B(B), .QW(QW), .CW(CW), .CSTEP(CSTEP), .NW(NW), .AW(AW)) dut (
        .clk(clk), .rst(rst), .q_valid(q_valid), .q_ready(q_ready), .q_data(q_data),
        .key_count(key_count), .kr_en(kr_en), .kr_addr(kr_addr), .kr_idx(kr_idx),
        .kr_norm(kr_norm), .s_valid(s_valid), .s_last(s_last), .s_score(s_score)
    );

    // Key storage model: one-cycle read latency
    logic [D*B-1:0] m_idx [NK];
    logic [NW-1:0]  m_norm [NK];
    always @(posedge clk) if (kr_en) begin
        kr_idx  <= m_idx[kr_addr];
        kr_norm <= m_norm[kr_addr];
    end

    longint exp_score[$];
    bit     exp_last[$];
    int     rd_stamp[$];

    task automatic check(input bit ok, input string req, input longint got, input longint exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: got %0d expected %0d (cycle %0d)", req, got, exp, cyc);
        end
    endtask

    function automatic longint cent(input int j);
        return longint'((2 * j - (NC - 1)) * CSTEP);
    endfunction

    // Monitor and scoreboard, sampling at the falling edge
    bit prev_kr = 1'b0;
    int exp_addr = 0, acc_cyc = 0;
    always @(negedge clk) if (!rst) begin
        if (q_valid && q_ready) acc_cyc = cyc;
        if (kr_en) begin
            if (!prev_kr) begin
                exp_addr = 0;
                check(cyc - acc_cyc == NC + 2, "R5 first read delay", cyc - acc_cyc, NC + 2);
            end
            check(int'(kr_addr) == exp_addr, "R6 read address", kr_addr, exp_addr);
            exp_addr++;
            rd_stamp.push_back(cyc);
        end
        prev_kr = kr_en;
        if (s_valid) begin
            check(!q_ready, "R10 score while idle", q_ready, 0);
            if (exp_score.size() == 0 || rd_stamp.size() == 0) begin
                check(1'b0, "R2 unexpected score", longint'($signed(s_score)), 0);
            end else begin
                int st;
                longint es;
                bit el;
                st = rd_stamp.pop_front();
                es = exp_score.pop_front();
                el = exp_last.pop_front();
                check(cyc - st == 3, "R7 score latency", cyc - st, 3);
                check(longint'($signed(s_score)) == es, "R3/R4 score value", longint'($signed(s_score)), es);
                check(s_last == el, "R8 last flag", s_last, el);
            end
        end
    end

    task automatic run_query(input int t, input int mode, input bit poke_busy);
        logic signed [QW-1:0] qv [D];
        for (int c = 0; c < D; c++) begin
            case (mode)
                1: qv[c] = -8'sd128;
                2: qv[c] = (c % 2 == 0) ? 8'sd127 : -8'sd128;
                default: qv[c] = QW'($urandom);
            endcase
            q_data[c*QW +: QW] = qv[c];
        end
        for (int k = 0; k < t; k++) begin
            longint acc = 0;
            for (int c = 0; c < D; c++) begin
                int ix;
                case (mode)
                    1: ix = 0;
                    2: ix = (c + k) % NC;
                    default: ix = int'($urandom % NC);
                endcase
                m_idx[k][c*B +: B] = B'(ix);
                acc += longint'(qv[c]) * cent(ix);
            end
            case (mode)
                1: m_norm[k] = 8'hFF;
                2: m_norm[k] = (k % 3 == 0) ? 8'd0 : NW'(k * 7 + 1);
                default: m_norm[k] = NW'($urandom);
            endcase
            exp_score.push_back(acc * longint'(m_norm[k]));
            exp_last.push_back(k == t - 1);
        end
        @(posedge clk); #1;
        key_count = (AW+1)'(t);
        q_valid = 1'b1;
        do @(negedge clk); while (!q_ready);
        @(posedge clk); #1;
        q_valid = 1'b0;
        if (poke_busy) begin
            repeat (12) @(posedge clk);
            #1;
            q_data = ~q_data;
            key_count = (AW+1)'(3);
            q_valid = 1'b1;
            for (int i = 0; i < 5; i++) begin
                @(negedge clk);
                check(!q_ready, "R2 ready low while busy", q_ready, 0);
            end
            @(posedge clk); #1;
            q_valid = 1'b0;
        end
        while (exp_score.size() != 0) @(negedge clk);
        @(negedge clk);
        check(q_ready, "R2 ready after last score", q_ready, 1);
    endtask

    initial begin
        repeat (5) @(posedge clk);
        #1;
        rst = 1'b0;
        @(negedge clk);
        check(q_ready == 1'b1, "R1 q_ready after reset", q_ready, 1);
        check(s_valid == 1'b0, "R1 s_valid after reset", s_valid, 0);
        check(kr_en == 1'b0, "R1 kr_en after reset", kr_en, 0);
        check(s_last == 1'b0, "R1 s_last after reset", s_last, 0);
        run_query(5, 0, 1'b0);
        run_query(4, 1, 1'b0);
        run_query(1, 2, 1'b0);   // R8 single key carries last
        run_query(NK, 0, 1'b0);  // R9 full key count
        run_query(20, 2, 1'b1);  // R2 request while busy is ignored
        run_query(7, 0, 1'b0);
        repeat (10) @(negedge clk);
        check(rd_stamp.size() == 0, "R6 read count matches scores", rd_stamp.size(), 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: run did not complete");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
        $finish;
    end

endmodule